// File: doc/BRIEF.md
# Scaled Flow-Control Credit Gate

This block sits on the transmit side of a packet link and decides, one request at a time, whether a packet may leave. Three traffic classes (posted, non-posted, completion) each carry two credit pools, one counted in headers and one counted in data units. That gives six independent pools.

When the link comes up, the link partner's advertised credit values are loaded together with a per-pool multiplier of 1, 4 or 16. The block turns them into absolute limits. It then counts what transmitted packets consume and what later update messages return, with returned amounts multiplied by the same per-pool factor. A request names its class and the data units it needs; it always needs exactly one header credit. One cycle later the block answers with either a grant pulse or a deny pulse. A granted packet's credits are charged at that same clock edge.

Because the multipliers widen the limits, every pool counter is four bits wider than its advertised field. This keeps the largest scaled values, 2032 headers and 32752 data units, inside the comparison window.

Top module: `fc_credit_gate`

## Requirements
- R1: After reset, `grant` and `deny` are low and no pool is loaded. A request made before the first load is answered with `deny`.
- R2: A cycle with `init_valid` high loads all six pools and clears their consumed counts. The scale codes are 0 for 1x, 1 for 4x, 2 for 16x, and 3, which is treated as 1x. Each pool's limit becomes its advertised value times its factor.
- R3: `req_kind` uses 0 for posted, 1 for non-posted, 2 for completion and 3 for invalid, which is always denied. A request is granted only when both the header pool (need 1) and the data pool (need `req_dat`) of its class allow it.
- R4: A pool allows a need when (limit − (consumed + need)) mod 2^N ≤ 2^(N−1). N is the advertised field width plus 4, which is 12 for headers and 16 for data at the defaults.
- R5: A pool loaded with an advertised value of 0 never gates a request, and updates addressed to it have no effect.
- R6: A cycle with `upd_valid` high adds `upd_hdr` and `upd_dat` to the header and data limits of class `upd_kind`. Each amount is first multiplied by the factor stored for that pool.
- R7: Every request yields exactly one one-cycle pulse, on `grant` or on `deny`, in the cycle after the request. A granted request's credits are charged at that edge, so the next request sees them.
- R8: An update and a granted request that touch the same class in the same cycle both take effect. The request is judged against the limits as they stood before that edge.
- R9: At 16x, a header pool loaded with 127 admits 2032 headers, and a data pool loaded with 2047 admits 32752 data units, without wrapping.
- R10: A load while traffic is running replaces all limits and factors and clears all consumed counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_valid | input | 1 | Load all six pools this cycle |
| init_hdr | input | 3x8 | Advertised header credits per class |
| init_hdr_scale | input | 3x2 | Header scale code per class |
| init_dat | input | 3x12 | Advertised data credits per class |
| init_dat_scale | input | 3x2 | Data scale code per class |
| upd_valid | input | 1 | Credit return this cycle |
| upd_kind | input | 2 | Class of the credit return |
| upd_hdr | input | 8 | Returned header credits, unscaled |
| upd_dat | input | 12 | Returned data credits, unscaled |
| req_valid | input | 1 | Packet request this cycle |
| req_kind | input | 2 | Class of the requested packet |
| req_dat | input | 10 | Data credits the packet needs |
| grant | output | 1 | Registered pulse: packet admitted |
| deny | output | 1 | Registered pulse: packet refused |

## Verification
The properties assume that `init_valid` is never high in the same cycle as `req_valid` or `upd_valid`. They also assume that returned credits never push a pool more than half the counter range ahead of its consumed count, because the modular window would otherwise misread the headroom. The stimulus respects both: loads, updates and requests are issued in separate steps, except where R8 deliberately pairs an update with a request. Returned amounts are small next to every pool's range. The bench's reference model also assumes requests never ask for more than the `req_dat` width can carry.

// File: rtl/fcg_pkg.sv
package fcg_pkg;
  typedef enum logic [1:0] {
    FC_POSTED    = 2'd0,
    FC_NONPOSTED = 2'd1,
    FC_COMPL     = 2'd2,
    FC_BAD       = 2'd3
  } fc_kind_e;

  typedef enum logic [1:0] {
    SC_X1  = 2'd0,
    SC_X4  = 2'd1,
    SC_X16 = 2'd2,
    SC_RSV = 2'd3
  } fc_scale_e;

  localparam int NUM_CLASS   = 3;
  localparam int SCALE_EXTRA = 4;
endpackage

// File: rtl/fcg_scaler.sv
module fcg_scaler
  import fcg_pkg::*;
#(
  parameter int IN_W = 8
) (
  input  logic [IN_W-1:0]             raw,
  input  logic [1:0]                  sel,
  output logic [IN_W+SCALE_EXTRA-1:0] scaled
);
  localparam int OUT_W = IN_W + SCALE_EXTRA;

  logic [OUT_W-1:0] wide;
  assign wide = OUT_W'(raw);

  always_comb begin
    case (fc_scale_e'(sel))
      SC_X4:   scaled = wide << 2;
      SC_X16:  scaled = wide << 4;
      default: scaled = wide;
    endcase
  end
endmodule

// File: rtl/fcg_slot.sv
module fcg_slot
  import fcg_pkg::*;
#(
  parameter int ADV_W  = 8,
  parameter int NEED_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [ADV_W-1:0]  ld_raw,
  input  logic [1:0]        ld_sel,
  input  logic              add_en,
  input  logic [ADV_W-1:0]  add_raw,
  input  logic              take_en,
  input  logic [NEED_W-1:0] need,
  output logic              ok
);
  localparam int W = ADV_W + SCALE_EXTRA;
  localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] lim_q, used_q;
  logic [1:0]   sel_q;
  logic         inf_q;
  logic [W-1:0] ld_scaled, add_scaled, need_ext, room;

  fcg_scaler #(.IN_W(ADV_W)) u_ld_scale (
    .raw(ld_raw), .sel(ld_sel), .scaled(ld_scaled)
  );

  fcg_scaler #(.IN_W(ADV_W)) u_add_scale (
    .raw(add_raw), .sel(sel_q), .scaled(add_scaled)
  );

  assign need_ext = W'(need);
  assign room     = lim_q - (used_q + need_ext);
  assign ok       = inf_q || (room <= HALF);

  always_ff @(posedge clk) begin
    if (rst) begin
      lim_q  <= '0;
      used_q <= '0;
      sel_q  <= SC_X1;
      inf_q  <= 1'b0;
    end else if (ld_en) begin
      lim_q  <= ld_scaled;
      used_q <= '0;
      sel_q  <= ld_sel;
      inf_q  <= (ld_raw == '0);
    end else begin
      if (add_en && !inf_q) lim_q <= lim_q + add_scaled;
      if (take_en)          used_q <= used_q + need_ext;
    end
  end
endmodule

// File: rtl/fc_credit_gate.sv
module fc_credit_gate
  import fcg_pkg::*;
#(
  parameter int HDR_ADV_W = 8,
  parameter int DAT_ADV_W = 12,
  parameter int NEED_W    = 10
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 init_valid,
  input  logic [NUM_CLASS-1:0][HDR_ADV_W-1:0]  init_hdr,
  input  logic [NUM_CLASS-1:0][1:0]            init_hdr_scale,
  input  logic [NUM_CLASS-1:0][DAT_ADV_W-1:0]  init_dat,
  input  logic [NUM_CLASS-1:0][1:0]            init_dat_scale,
  input  logic                                 upd_valid,
  input  logic [1:0]                           upd_kind,
  input  logic [HDR_ADV_W-1:0]                 upd_hdr,
  input  logic [DAT_ADV_W-1:0]                 upd_dat,
  input  logic                                 req_valid,
  input  logic [1:0]                           req_kind,
  input  logic [NEED_W-1:0]                    req_dat,
  output logic                                 grant,
  output logic                                 deny
);
  logic [3:0] hdr_ok, dat_ok;
  logic       ready_q, pass, take;

  assign hdr_ok[3] = 1'b0;
  assign dat_ok[3] = 1'b0;

  assign pass = ready_q && (fc_kind_e'(req_kind) != FC_BAD)
                && hdr_ok[req_kind] && dat_ok[req_kind];
  assign take = req_valid && pass && !init_valid;

  for (genvar c = 0; c < NUM_CLASS; c++) begin : g_class
    logic hit_upd, hit_req;
    assign hit_upd = upd_valid && (upd_kind == 2'(c));
    assign hit_req = take && (req_kind == 2'(c));

    fcg_slot #(.ADV_W(HDR_ADV_W), .NEED_W(1)) u_hdr (
      .clk(clk), .rst(rst),
      .ld_en(init_valid), .ld_raw(init_hdr[c]), .ld_sel(init_hdr_scale[c]),
      .add_en(hit_upd), .add_raw(upd_hdr),
      .take_en(hit_req), .need(1'b1),
      .ok(hdr_ok[c])
    );

    fcg_slot #(.ADV_W(DAT_ADV_W), .NEED_W(NEED_W)) u_dat (
      .clk(clk), .rst(rst),
      .ld_en(init_valid), .ld_raw(init_dat[c]), .ld_sel(init_dat_scale[c]),
      .add_en(hit_upd), .add_raw(upd_dat),
      .take_en(hit_req), .need(req_dat),
      .ok(dat_ok[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      grant   <= 1'b0;
      deny    <= 1'b0;
    end else begin
      if (init_valid) ready_q <= 1'b1;
      grant <= req_valid && pass;
      deny  <= req_valid && !pass;
    end
  end
endmodule

// File: rtl/fcg_checker.sv
module fcg_checker (
  input logic       clk,
  input logic       rst,
  input logic       init_valid,
  input logic       req_valid,
  input logic [1:0] req_kind,
  input logic       grant,
  input logic       deny
);
  logic seen_q;

  always_ff @(posedge clk) begin
    if (rst)             seen_q <= 1'b0;
    else if (init_valid) seen_q <= 1'b1;
  end

  a_r7_one_pulse: assert property (@(posedge clk) disable iff (rst)
    $onehot0({grant, deny}));

  a_r7_answered: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (grant || deny));

  a_r7_no_stray: assert property (@(posedge clk) disable iff (rst)
    (grant || deny) |-> $past(req_valid));

  a_r1_no_early_grant: assert property (@(posedge clk) disable iff (rst)
    grant |-> seen_q);

  a_r3_bad_kind: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 2'd3) |=> deny);
endmodule

bind fc_credit_gate fcg_checker u_fcg_checker (
  .clk(clk), .rst(rst), .init_valid(init_valid), .req_valid(req_valid),
  .req_kind(req_kind), .grant(grant), .deny(deny)
);

// File: tb/fc_credit_gate_bench.sv
module fc_credit_gate_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic init_valid = 1'b0;
  logic [2:0][7:0]  init_hdr = '0;
  logic [2:0][1:0]  init_hdr_scale = '0;
  logic [2:0][11:0] init_dat = '0;
  logic [2:0][1:0]  init_dat_scale = '0;
  logic upd_valid = 1'b0;
  logic [1:0] upd_kind = '0;
  logic [7:0] upd_hdr = '0;
  logic [11:0] upd_dat = '0;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = '0;
  logic [9:0] req_dat = '0;
  logic grant, deny;

  int total = 0;
  int bad = 0;

  // model state: index 0..2 header pools, 3..5 data pools
  int m_lim[6];
  int m_used[6];
  int m_sel[6];
  bit m_inf[6];
  bit m_ready = 0;

  always #5 clk = ~clk;

  fc_credit_gate u_fc_credit_gate (.*);

  function automatic int mult(int sel);
    return (sel == 1) ? 4 : (sel == 2) ? 16 : 1;
  endfunction

  function automatic int pmask(int idx);
    return (idx < 3) ? 4095 : 65535;
  endfunction

  function automatic bit fits(int idx, int need);
    int half;
    half = (idx < 3) ? 2048 : 32768;
    if (m_inf[idx]) return 1'b1;
    return ((m_lim[idx] - (m_used[idx] + need)) & pmask(idx)) <= half;
  endfunction

  task automatic check(string tag, bit eg, bit ed);
    total++;
    if (grant !== eg || deny !== ed) begin
      bad++;
      $display("FAIL %s: grant=%b deny=%b expected grant=%b deny=%b",
               tag, grant, deny, eg, ed);
    end
  endtask

  // called at a negedge; returns at the following negedge
  task automatic step(string tag, bit rq, int kind, int dat,
                      bit up, int ukind, int uh, int ud);
    bit eg, ed;
    req_valid = rq; req_kind = 2'(kind); req_dat = 10'(dat);
    upd_valid = up; upd_kind = 2'(ukind); upd_hdr = 8'(uh); upd_dat = 12'(ud);
    @(posedge clk);
    eg = rq && m_ready && kind < 3 && fits(kind, 1) && fits(kind + 3, dat);
    ed = rq && !eg;
    if (eg) begin
      m_used[kind]     = (m_used[kind] + 1) & pmask(kind);
      m_used[kind + 3] = (m_used[kind + 3] + dat) & pmask(kind + 3);
    end
    if (up && ukind < 3) begin
      if (!m_inf[ukind])
        m_lim[ukind] = (m_lim[ukind] + uh * mult(m_sel[ukind])) & pmask(ukind);
      if (!m_inf[ukind + 3])
        m_lim[ukind + 3] = (m_lim[ukind + 3] + ud * mult(m_sel[ukind + 3])) & pmask(ukind + 3);
    end
    @(negedge clk);
    check(tag, eg, ed);
    req_valid = 0; upd_valid = 0;
  endtask

  task automatic load(string tag, input int h[3], input int hs[3],
                      input int d[3], input int ds[3]);
    for (int c = 0; c < 3; c++) begin
      init_hdr[c] = 8'(h[c]);  init_hdr_scale[c] = 2'(hs[c]);
      init_dat[c] = 12'(d[c]); init_dat_scale[c] = 2'(ds[c]);
    end
    init_valid = 1;
    @(posedge clk);
    for (int c = 0; c < 3; c++) begin
      m_lim[c] = h[c] * mult(hs[c]);     m_sel[c] = hs[c];
      m_inf[c] = (h[c] == 0);            m_used[c] = 0;
      m_lim[c + 3] = d[c] * mult(ds[c]); m_sel[c + 3] = ds[c];
      m_inf[c + 3] = (d[c] == 0);        m_used[c + 3] = 0;
    end
    m_ready = 1;
    @(negedge clk);
    init_valid = 0;
    check(tag, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 6; i++) begin
      m_lim[i] = 0; m_used[i] = 0; m_sel[i] = 0; m_inf[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1 reset outputs", 1'b0, 1'b0);
    step("R1 request before load", 1, 0, 0, 0, 0, 0, 0);

    // posted: hdr 2 @1x, data 10 @4x; non-posted: hdr inf, data 5 @16x;
    // completion: hdr 127 @16x, data 2047 @16x
    load("R2 first load", '{2, 0, 127}, '{0, 0, 2}, '{10, 5, 2047}, '{1, 2, 2});

    step("R3 posted grant 1", 1, 0, 16, 0, 0, 0, 0);
    step("R4 posted grant 2", 1, 0, 16, 0, 0, 0, 0);
    step("R4 posted header exhausted", 1, 0, 0, 0, 0, 0, 0);
    step("R6 posted update", 0, 0, 0, 1, 0, 1, 2);
    step("R6 posted grant after update", 1, 0, 16, 0, 0, 0, 0);
    step("R6 header room to spare", 0, 0, 0, 1, 0, 5, 0);
    step("R4 data exhausted only", 1, 0, 1, 0, 0, 0, 0);
    step("R3 header-only fits", 1, 0, 0, 0, 0, 0, 0);

    step("R5 update to infinite header", 0, 0, 0, 1, 1, 9, 0);
    step("R5 non-posted full data", 1, 1, 80, 0, 0, 0, 0);
    step("R5 non-posted data exhausted", 1, 1, 1, 0, 0, 0, 0);
    step("R3 invalid kind", 1, 3, 0, 0, 0, 0, 0);

    // same-cycle update and request
    step("R8 request sees old limit", 1, 1, 16, 1, 1, 0, 1);
    step("R8 request sees new limit", 1, 1, 16, 0, 0, 0, 0);
    step("R8 consume with update", 1, 0, 0, 1, 0, 1, 4);
    step("R8 both applied", 1, 0, 16, 0, 0, 0, 0);

    for (int i = 0; i < 32; i++)
      step("R9 completion fill", 1, 2, 1023, 0, 0, 0, 0);
    step("R9 completion data limit", 1, 2, 1023, 0, 0, 0, 0);
    step("R9 completion tail", 1, 2, 16, 0, 0, 0, 0);
    step("R9 completion over tail", 1, 2, 1, 0, 0, 0, 0);

    // reserved scale code on posted header counts as 1x
    load("R10 reload", '{2, 3, 1}, '{3, 0, 0}, '{0, 1, 1}, '{0, 0, 0});
    step("R2 reserved scale grant 1", 1, 0, 500, 0, 0, 0, 0);
    step("R2 reserved scale grant 2", 1, 0, 500, 0, 0, 0, 0);
    step("R2 reserved scale is 1x", 1, 0, 0, 0, 0, 0, 0);
    step("R10 consumed cleared", 1, 2, 1, 0, 0, 0, 0);
    step("R10 new limit applies", 1, 2, 0, 0, 0, 0, 0);
    step("R7 idle no pulse", 0, 0, 0, 0, 0, 0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule